// File: doc/BRIEF.md
# Page Table Walker

This block translates one virtual address at a time by reading page table entries from memory. It supports a two-level scheme with 32-bit entries and 4 KiB pages (mode Sv32) and a three-level scheme with 64-bit entries (mode Sv39). A request carries the virtual address, the access kind, the effective privilege and two permission modifiers: one lets supervisor code touch user pages, the other lets loads read execute-only pages. The root page number and the translation mode arrive on static inputs and are sampled when the request is accepted.

The walker reads one entry per level over a read port that has a valid/ready handshake, and data returns later with an optional error flag. A leaf entry passes through a fixed set of checks. If the accessed or dirty flag has to be set, the updated entry is stored back over a write port before the walker answers. The answer is a one-cycle pulse that carries either a physical address with read/write/execute rights or a fault flag. Only one translation is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and neither memory port is active while the walker is idle.
- R2: When `xlat_mode` is 0 (bare) or `req_priv` is 3 (machine), the walker does not read memory. `rsp_valid` rises in the cycle after acceptance with `rsp_paddr` = `req_vaddr[55:0]`, `rsp_perm` = 3'b111 and no fault. This holds in any mode.
- R3: In mode 2 (Sv39), bits 63..38 of the virtual address must all be equal, or the request faults without a memory read. Mode 3 with a non-machine privilege also faults without a read.
- R4: Each entry is read at byte address base*4096 + index*size, and the base starts at `root_ppn`. In Sv32 the size is 4 and the indices are va[31:22] and then va[21:12]. In Sv39 the size is 8 and the indices are va[38:30], va[29:21] and va[20:12]. The address is held stable while `mem_rd_valid` waits for ready.
- R5: Entry bits are V=0, R=1, W=2, X=3, U=4, A=6 and D=7. The page number starts at bit 10 and is 22 bits wide in Sv32 and 44 bits wide in Sv39. An entry with V clear faults. An entry with V set and R, W, X all clear is a pointer whose page number becomes the next base. A pointer at the last level faults.
- R6: A leaf with W set and R clear faults.
- R7: Privilege codes are 0 for user and 1 for supervisor. A leaf with U set faults unless the privilege is user, or unless `req_sum` is 1 and the access is not a fetch. A leaf with U clear faults unless the privilege is supervisor.
- R8: A leaf found above level 0 faults if its page number is not zero in the low 10 bits per level below it (Sv32) or 9 bits per level below it (Sv39).
- R9: Access codes are 0 for fetch, 1 for load and 2 for store. A load needs R, or X with `req_mxr`=1. A store needs W. A fetch needs X. Otherwise the request faults.
- R10: On success A is set, and D is also set for a store. The updated entry is written to the same address only if it differs from the read value. The response follows acceptance of the write.
- R11: On success `rsp_paddr` is the leaf page number with its bits below the leaf level replaced by the matching virtual page number bits, followed by va[11:0]. `rsp_perm` is {X, W and (store or D), R or (X and MXR)}. On a fault `rsp_perm` is 0.
- R12: A read response with `mem_rd_err`=1 makes the request fault.
- R13: `req_ready` is low from acceptance until the response, and `rsp_valid` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Loads may read execute-only pages |
| root_ppn | input | PA_W-12 | Root table page number |
| xlat_mode | input | 2 | 0 bare, 1 Sv32, 2 Sv39, 3 reserved |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | PA_W | Entry byte address |
| mem_rd_rvalid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Entry value (Sv32 uses bits 31:0) |
| mem_rd_err | input | 1 | Read failed |
| mem_wr_valid | output | 1 | Entry write-back request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_addr | output | PA_W | Write-back byte address |
| mem_wr_data | output | 64 | Updated entry |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | PA_W | Physical address |
| rsp_perm | output | 3 | {X, W, R} rights |
| rsp_fault | output | 1 | Page fault |

## Verification
A bare or machine-mode result is due exactly one cycle after acceptance, as is a fault from the canonical-address or reserved-mode check. The bench measures that latency in clock cycles and requires 1. A walked result is due one cycle after the last read returns, or one cycle after the write-back is accepted when A or D changes. Walk latency therefore depends on the memory model. The bench polls `rsp_valid` on falling edges and checks the number of reads and writes the walk made against the expected depth. The checker pins the single-cycle latencies and the one-cycle response pulse.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        req_priv,
  input  logic              req_sum,
  input  logic              req_mxr,
  input  logic [PA_W-13:0]  root_ppn,
  input  logic [1:0]        xlat_mode,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_rvalid,
  input  logic [63:0]       mem_rd_data,
  input  logic              mem_rd_err,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [PA_W-1:0]   mem_wr_addr,
  output logic [63:0]       mem_wr_data,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_perm,
  output logic              rsp_fault
);
  localparam int PPN_W = PA_W - 12;
  localparam logic [1:0] MODE_BARE = 2'd0, MODE_SV32 = 2'd1, MODE_SV39 = 2'd2;
  localparam logic [1:0] ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2;
  localparam logic [1:0] PRV_U = 2'd0, PRV_S = 2'd1, PRV_M = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WR, S_DONE} st_t;

  st_t              st;
  logic [63:0]      va_q;
  logic [1:0]       acc_q, priv_q, lvl_q;
  logic             sum_q, mxr_q, sv32_q;
  logic [PPN_W-1:0] base_q;
  logic [63:0]      wr_q;
  logic [PA_W-1:0]  pa_q;
  logic [2:0]       perm_q;
  logic             fault_q;

  logic [9:0]       idx;
  logic [4:0]       shamt;
  logic [PA_W-1:0]  ent_addr;
  logic [PPN_W-1:0] ppn, lowmask, vpn;
  logic             e_v, e_r, e_w, e_x, e_u, e_d;
  logic             is_ptr, acc_bad, priv_bad, leaf_bad, canon;
  logic [63:0]      new_pte;
  logic             unused_bits;

  always_comb begin
    if (sv32_q) begin
      idx   = va_q[12 + 10*int'(lvl_q) +: 10];
      shamt = 5'(10*int'(lvl_q));
    end else begin
      idx   = {1'b0, va_q[12 + 9*int'(lvl_q) +: 9]};
      shamt = 5'(9*int'(lvl_q));
    end
  end

  assign ent_addr = {base_q, 12'h000} +
                    (sv32_q ? PA_W'({idx, 2'b00}) : PA_W'({idx, 3'b000}));
  assign ppn      = sv32_q ? PPN_W'(mem_rd_data[31:10]) : PPN_W'(mem_rd_data[53:10]);
  assign lowmask  = (PPN_W'(1) << shamt) - PPN_W'(1);
  assign vpn      = va_q[12 +: PPN_W];

  assign {e_d, e_u, e_x, e_w, e_r, e_v} = {mem_rd_data[7], mem_rd_data[4:0]};
  assign is_ptr  = e_v && !e_r && !e_w && !e_x;

  always_comb begin
    case (acc_q)
      ACC_LOAD:  acc_bad = !(e_r || (e_x && mxr_q));
      ACC_STORE: acc_bad = !e_w;
      ACC_FETCH: acc_bad = !e_x;
      default:   acc_bad = 1'b1;
    endcase
  end

  assign priv_bad = e_u ? (priv_q != PRV_U && !(sum_q && acc_q != ACC_FETCH))
                        : (priv_q != PRV_S);
  assign leaf_bad = !e_v || (e_w && !e_r) || priv_bad || (|(ppn & lowmask)) || acc_bad;
  assign new_pte  = mem_rd_data | 64'h40 | ((acc_q == ACC_STORE) ? 64'h80 : 64'h0);
  assign canon    = (&req_vaddr[63:38]) || !(|req_vaddr[63:38]);

  assign unused_bits = ^{mem_rd_data[63:54], mem_rd_data[9:8], mem_rd_data[5], va_q[63:56]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      priv_q  <= '0;
      lvl_q   <= '0;
      sum_q   <= 1'b0;
      mxr_q   <= 1'b0;
      sv32_q  <= 1'b0;
      base_q  <= '0;
      wr_q    <= '0;
      pa_q    <= '0;
      perm_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= req_acc;
          priv_q <= req_priv;
          sum_q  <= req_sum;
          mxr_q  <= req_mxr;
          sv32_q <= (xlat_mode == MODE_SV32);
          base_q <= root_ppn;
          lvl_q  <= (xlat_mode == MODE_SV32) ? 2'd1 : 2'd2;
          pa_q   <= '0;
          perm_q <= '0;
          fault_q <= 1'b0;
          if (xlat_mode == MODE_BARE || req_priv == PRV_M) begin
            pa_q   <= req_vaddr[PA_W-1:0];
            perm_q <= 3'b111;
            st     <= S_DONE;
          end else if (xlat_mode != MODE_SV32 &&
                       (xlat_mode != MODE_SV39 || !canon)) begin
            fault_q <= 1'b1;
            st      <= S_DONE;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: if (mem_rd_ready) st <= S_WAIT;
        S_WAIT: if (mem_rd_rvalid) begin
          if (mem_rd_err) begin
            fault_q <= 1'b1;
            st      <= S_DONE;
          end else if (is_ptr) begin
            if (lvl_q == 2'd0) begin
              fault_q <= 1'b1;
              st      <= S_DONE;
            end else begin
              base_q <= ppn;
              lvl_q  <= lvl_q - 2'd1;
              st     <= S_RD;
            end
          end else if (leaf_bad) begin
            fault_q <= 1'b1;
            st      <= S_DONE;
          end else begin
            pa_q   <= {(ppn & ~lowmask) | (vpn & lowmask), va_q[11:0]};
            perm_q <= {e_x, e_w && (acc_q == ACC_STORE || e_d), e_r || (e_x && mxr_q)};
            wr_q   <= new_pte;
            st     <= (new_pte != mem_rd_data) ? S_WR : S_DONE;
          end
        end
        S_WR:    if (mem_wr_ready) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == S_IDLE);
  assign mem_rd_valid = (st == S_RD);
  assign mem_rd_addr  = ent_addr;
  assign mem_wr_valid = (st == S_WR);
  assign mem_wr_addr  = ent_addr;
  assign mem_wr_data  = wr_q;
  assign rsp_valid    = (st == S_DONE);
  assign rsp_paddr    = pa_q;
  assign rsp_perm     = perm_q;
  assign rsp_fault    = fault_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [63:0]      req_vaddr,
  input logic [1:0]       req_acc,
  input logic [1:0]       req_priv,
  input logic             req_sum,
  input logic             req_mxr,
  input logic [PA_W-13:0] root_ppn,
  input logic [1:0]       xlat_mode,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             mem_rd_rvalid,
  input logic [63:0]      mem_rd_data,
  input logic             mem_rd_err,
  input logic             mem_wr_valid,
  input logic             mem_wr_ready,
  input logic [PA_W-1:0]  mem_wr_addr,
  input logic [63:0]      mem_wr_data,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [2:0]       rsp_perm,
  input logic             rsp_fault
);
  logic unused_chk;
  assign unused_chk = ^{req_vaddr[37:0], req_acc, req_sum, req_mxr, root_ppn, mem_rd_data, rsp_paddr};

  logic accept, passthru, noncanon;
  assign accept   = req_valid && req_ready;
  assign passthru = (xlat_mode == 2'd0) || (req_priv == 2'd3);
  assign noncanon = !((&req_vaddr[63:38]) || !(|req_vaddr[63:38]));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_valid && !mem_wr_valid));

  p_pass_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && passthru) |=> (rsp_valid && !rsp_fault && rsp_perm == 3'b111));

  p_noncanon_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !passthru && xlat_mode == 2'd2 && noncanon) |=> (rsp_valid && rsp_fault));

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_fault_noperm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_perm == 3'b000));

  p_err_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_rvalid && mem_rd_err && !req_ready && !rsp_valid) |=> (rsp_valid && rsp_fault));

  p_busy_after_accept_r13: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) chk_i (.*);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 56;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0] req_acc = '0, req_priv = '0, xlat_mode = '0;
  logic req_sum = 1'b0, req_mxr = 1'b0;
  logic [PA_W-13:0] root_ppn = '0;
  logic mem_rd_valid, mem_rd_ready, mem_rd_rvalid = 1'b0, mem_rd_err = 1'b0;
  logic [PA_W-1:0] mem_rd_addr, mem_wr_addr;
  logic [63:0] mem_rd_data = '0, mem_wr_data;
  logic mem_wr_valid, mem_wr_ready;
  logic rsp_valid, rsp_fault;
  logic [PA_W-1:0] rsp_paddr;
  logic [2:0] rsp_perm;

  assign mem_rd_ready = 1'b1;
  assign mem_wr_ready = 1'b1;

  pt_walker #(.PA_W(PA_W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [55:0] last_wa = '0;
  logic [63:0] last_wd = '0;
  logic err_en = 1'b0;
  logic [55:0] err_addr = '0;
  logic [63:0] mem [logic [55:0]];

  always @(posedge clk) begin
    mem_rd_rvalid <= 1'b0;
    mem_rd_err    <= 1'b0;
    if (mem_rd_valid && mem_rd_ready) begin
      mem_rd_rvalid <= 1'b1;
      mem_rd_data   <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 64'h0;
      mem_rd_err    <= err_en && (mem_rd_addr == err_addr);
      rd_cnt        <= rd_cnt + 1;
    end
    if (mem_wr_valid && mem_wr_ready) begin
      mem[mem_wr_addr] = mem_wr_data;
      last_wa <= mem_wr_addr;
      last_wd <= mem_wr_data;
      wr_cnt  <= wr_cnt + 1;
    end
  end

  logic [55:0] r_pa;
  logic [2:0]  r_perm;
  logic        r_fault;
  int r_lat, r_rd, r_wr;

  function automatic logic [63:0] pte39(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'b0, ppn, 2'b00, fl};
  endfunction
  function automatic logic [63:0] pte32(input logic [21:0] ppn, input logic [7:0] fl);
    return {32'b0, ppn, 2'b00, fl};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic run(input logic [1:0] md, input logic [43:0] root, input logic [63:0] va,
                     input logic [1:0] acc, input logic [1:0] prv, input logic sum, input logic mxr);
    int rd0, wr0;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    xlat_mode = md; root_ppn = root; req_vaddr = va;
    req_acc = acc; req_priv = prv; req_sum = sum; req_mxr = mxr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    while (!rsp_valid && r_lat < 100) begin
      @(negedge clk);
      r_lat++;
    end
    r_pa = rsp_paddr; r_perm = rsp_perm; r_fault = rsp_fault;
    r_rd = rd_cnt - rd0; r_wr = wr_cnt - wr0;
    chk(rsp_valid, "R13 response seen", 64'(rsp_valid), 64'd1);
  endtask

  task automatic expect_ok(input string tag, input logic [55:0] pa, input logic [2:0] perm, input int nrd);
    chk(!r_fault, {tag, " fault"}, 64'(r_fault), 64'd0);
    chk(r_pa == pa, {tag, " paddr"}, 64'(r_pa), 64'(pa));
    chk(r_perm == perm, {tag, " perm"}, 64'(r_perm), 64'(perm));
    chk(r_rd == nrd, {tag, " reads"}, 64'(r_rd), 64'(nrd));
  endtask

  task automatic expect_fault(input string tag, input int nrd);
    chk(r_fault, {tag, " fault"}, 64'(r_fault), 64'd1);
    chk(r_perm == 3'b000, {tag, " perm R11"}, 64'(r_perm), 64'd0);
    chk(r_rd == nrd, {tag, " reads"}, 64'(r_rd), 64'(nrd));
    chk(r_wr == 0, {tag, " writes"}, 64'(r_wr), 64'd0);
  endtask

  localparam logic [43:0] ROOT39 = 44'h100;
  localparam logic [63:0] VA39 = 64'h4040_3123;
  localparam logic [55:0] LEAF_A = 56'h102018;
  localparam logic [55:0] MID_A = 56'h101010;
  localparam logic [55:0] TOP_A = 56'h100008;

  task automatic build39();
    mem[TOP_A]  = pte39(44'h101, 8'h01);
    mem[MID_A]  = pte39(44'h102, 8'h01);
    mem[LEAF_A] = pte39(44'h5555, 8'hC7);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
    chk(!mem_rd_valid && !mem_wr_valid, "R1 memory idle", 64'({mem_rd_valid, mem_wr_valid}), 64'd0);
  endtask

  task automatic t_passthru();
    run(2'd0, ROOT39, 64'h00AB_CDEF_0123_4567, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_ok("R2 bare", 56'hAB_CDEF_0123_4567, 3'b111, 0);
    chk(r_lat == 1, "R2 bare latency", 64'(r_lat), 64'd1);
    run(2'd2, ROOT39, 64'h00AB_CDEF_0123_4567, 2'd2, 2'd3, 1'b0, 1'b0);
    expect_ok("R2 machine", 56'hAB_CDEF_0123_4567, 3'b111, 0);
    chk(r_lat == 1, "R2 machine latency", 64'(r_lat), 64'd1);
  endtask

  task automatic t_canon();
    run(2'd2, ROOT39, 64'h0000_0040_0000_0000, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R3 noncanonical", 0);
    chk(r_lat == 1, "R3 latency", 64'(r_lat), 64'd1);
    mem[56'h100808] = pte39(44'h80000, 8'hC7);
    run(2'd2, ROOT39, 64'hFFFF_FFC0_4040_3123, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_ok("R3 canonical upper", 56'h8040_3123, 3'b011, 1);
    run(2'd3, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R3 reserved mode", 0);
  endtask

  task automatic t_walk39();
    build39();
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_ok("R4 R11 sv39 4K", 56'h5555123, 3'b011, 3);
    chk(r_wr == 0, "R10 no write when unchanged", 64'(r_wr), 64'd0);
  endtask

  task automatic t_ad();
    build39();
    mem[LEAF_A] = pte39(44'h5555, 8'h07);
    run(2'd2, ROOT39, VA39, 2'd2, 2'd1, 1'b0, 1'b0);
    expect_ok("R10 store", 56'h5555123, 3'b011, 3);
    chk(r_wr == 1 && last_wa == LEAF_A, "R10 store wb addr", 64'(last_wa), 64'(LEAF_A));
    chk(last_wd == pte39(44'h5555, 8'hC7), "R10 store wb data", last_wd, pte39(44'h5555, 8'hC7));
    mem[LEAF_A] = pte39(44'h5555, 8'h07);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_ok("R10 R11 load clean", 56'h5555123, 3'b001, 3);
    chk(last_wd == pte39(44'h5555, 8'h47), "R10 load wb data", last_wd, pte39(44'h5555, 8'h47));
  endtask

  task automatic t_ptr();
    build39();
    mem[MID_A] = 64'h0;
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R5 invalid entry", 2);
    build39();
    mem[LEAF_A] = pte39(44'h5555, 8'h01);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R5 pointer at last level", 3);
  endtask

  task automatic t_reserved();
    build39();
    mem[LEAF_A] = pte39(44'h5555, 8'hC5);
    run(2'd2, ROOT39, VA39, 2'd2, 2'd1, 1'b0, 1'b0);
    expect_fault("R6 write-only", 3);
    mem[LEAF_A] = pte39(44'h5555, 8'hCD);
    run(2'd2, ROOT39, VA39, 2'd0, 2'd1, 1'b0, 1'b0);
    expect_fault("R6 write-exec", 3);
  endtask

  task automatic t_user();
    build39();
    mem[LEAF_A] = pte39(44'h5555, 8'h5B);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R7 user page from S", 3);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b1, 1'b0);
    expect_ok("R7 user page with SUM", 56'h5555123, 3'b101, 3);
    run(2'd2, ROOT39, VA39, 2'd0, 2'd1, 1'b1, 1'b0);
    expect_fault("R7 fetch user page with SUM", 3);
    run(2'd2, ROOT39, VA39, 2'd0, 2'd0, 1'b0, 1'b0);
    expect_ok("R7 user fetch", 56'h5555123, 3'b101, 3);
    mem[LEAF_A] = pte39(44'h5555, 8'h43);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd0, 1'b0, 1'b0);
    expect_fault("R7 supervisor page from U", 3);
  endtask

  task automatic t_super();
    build39();
    mem[MID_A] = pte39(44'h200, 8'hC7);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_ok("R8 R11 2M page", 56'h203123, 3'b011, 2);
    mem[MID_A] = pte39(44'h201, 8'hC7);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R8 misaligned 2M", 2);
    mem[TOP_A] = pte39(44'h40000, 8'hC7);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_ok("R8 R11 1G page", 56'h4040_3123, 3'b011, 1);
    mem[TOP_A] = pte39(44'h40100, 8'hC7);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R8 misaligned 1G", 1);
  endtask

  task automatic t_access();
    build39();
    mem[LEAF_A] = pte39(44'h5555, 8'h49);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R9 load exec-only", 3);
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b1);
    expect_ok("R9 load exec-only MXR", 56'h5555123, 3'b101, 3);
    run(2'd2, ROOT39, VA39, 2'd0, 2'd1, 1'b0, 1'b0);
    expect_ok("R9 fetch", 56'h5555123, 3'b100, 3);
    mem[LEAF_A] = pte39(44'h5555, 8'h43);
    run(2'd2, ROOT39, VA39, 2'd2, 2'd1, 1'b0, 1'b0);
    expect_fault("R9 store read-only", 3);
    run(2'd2, ROOT39, VA39, 2'd0, 2'd1, 1'b0, 1'b0);
    expect_fault("R9 fetch no-exec", 3);
  endtask

  task automatic t_sv32();
    mem[56'h300014] = pte32(22'h301, 8'h01);
    mem[56'h30101C] = pte32(22'h3ABCD, 8'hC7);
    run(2'd1, 44'h300, 64'h0140_7456, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_ok("R4 R11 sv32 4K", 56'h3ABC_D456, 3'b011, 2);
    mem[56'h300014] = pte32(22'h400, 8'hC7);
    run(2'd1, 44'h300, 64'h0140_7456, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_ok("R8 sv32 4M page", 56'h40_7456, 3'b011, 1);
    mem[56'h300014] = pte32(22'h401, 8'hC7);
    run(2'd1, 44'h300, 64'h0140_7456, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R8 sv32 misaligned", 1);
  endtask

  task automatic t_memerr();
    build39();
    err_addr = MID_A;
    err_en = 1'b1;
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_fault("R12 read error", 2);
    err_en = 1'b0;
    run(2'd2, ROOT39, VA39, 2'd1, 2'd1, 1'b0, 1'b0);
    expect_ok("R12 recovery", 56'h5555123, 3'b011, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R13 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_canon();
    t_walk39();
    t_ad();
    t_ptr();
    t_reserved();
    t_user();
    t_super();
    t_access();
    t_sv32();
    t_memerr();
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R13 idle after response", 64'({req_ready, rsp_valid}), 64'd2);
    summary();
    $finish;
  end
endmodule